// File: doc/BRIEF.md
# Cache Intervention Responder

Each coherent core has one of these slaves on its intervention input. The directory sends it an intervention request. The request carries a command, a line index and an info part. The info part holds a self/system flag and the ID of the core being addressed. The block reads the line's local MSI state, applies the state change the command calls for, and returns a response. The response carries a code, the state the line held when the request arrived, and, for a dirty line that must be given up, both words of the line in two beats.

Interventions are handled one at a time. From acceptance until the last response beat is taken, no new request is accepted. Self interventions are echoes of the core's own coherent request, so they leave the cache untouched. The local state array and the two-word data store sit inside the block. The core's refill path loads them through a fill port.

Top module: `icr_intervention_responder`

## Requirements
- R1: After reset every line is Invalid, `req_ready_o` is high and `resp_valid_o` is low.
- R2: A system read-shared intervention (cmd 0) to a Modified line (state code 2) moves it to Shared (code 1). It answers with code 2 (data): word 0 in the first beat, then word 1 with `resp_last_o` high.
- R3: A system ownership intervention (cmd 1) to a Modified line moves it to Invalid (code 0). It returns both data words in two beats with code 2.
- R4: A system upgrade intervention (cmd 2) to a Shared or Modified line moves it to Invalid. It answers with a single beat of code 1 (ack) carrying data 0.
- R5: A system read-shared intervention to a Shared line leaves it Shared. A system ownership intervention to a Shared line invalidates it. Both answer with one ack beat.
- R6: A self intervention (`req_sys_i` low) changes no state and answers with one ack beat that reports the line's current state.
- R7: An intervention to an Invalid line answers with one ack beat that reports state Invalid.
- R8: A system intervention whose core ID differs from parameter `CORE_ID` changes no state and answers with an ack.
- R9: The first response beat appears in the cycle after acceptance. `req_ready_o` stays low until the final beat is taken. Under `resp_ready_i` low the response holds steady.
- R10: The fill port writes a line's state and both data words; fill state code 3 loads Invalid. A fill in a cycle where an intervention is accepted has no effect.
- R11: Command code 3 is reserved. It changes no state and answers with an ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Intervention request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_cmd_i | input | 2 | 0 read-shared, 1 ownership, 2 upgrade, 3 reserved |
| req_addr_i | input | IDX_W | Line index |
| req_sys_i | input | 1 | 1 system, 0 self |
| req_cid_i | input | CID_W | Addressed core ID |
| resp_valid_o | output | 1 | Response beat valid |
| resp_ready_i | input | 1 | Response beat taken |
| resp_code_o | output | 2 | 1 ack without data, 2 data |
| resp_state_o | output | 2 | Line state at request time (0 I, 1 S, 2 M) |
| resp_data_o | output | DATA_W | Line word for this beat, 0 on ack |
| resp_last_o | output | 1 | Final beat of the response |
| fill_valid_i | input | 1 | Fill write enable |
| fill_idx_i | input | IDX_W | Fill line index |
| fill_state_i | input | 2 | Fill state code |
| fill_d0_i | input | DATA_W | Fill word 0 |
| fill_d1_i | input | DATA_W | Fill word 1 |

## Verification
The hardest case to reach from the ports is a fill that arrives in the same edge as an accepted intervention. The bench drives both in one cycle and then probes the line with a self intervention, which exposes the state without changing it. The state left by each intervention is confirmed the same way, through a later self or system request to the same line. A pending response is held with `resp_ready_i` low for several cycles while stability and the blocked `req_ready_o` are sampled.

// File: rtl/icr_pkg.sv
package icr_pkg;
  typedef enum logic [1:0] {MSI_I = 2'd0, MSI_S = 2'd1, MSI_M = 2'd2} msi_e;
  typedef enum logic [1:0] {IV_RDSH = 2'd0, IV_RDOW = 2'd1, IV_UPG = 2'd2, IV_RSVD = 2'd3} ivcmd_e;
  typedef enum logic [1:0] {RC_NONE = 2'd0, RC_ACK = 2'd1, RC_DATA = 2'd2} rcode_e;

  typedef struct packed {
    logic upd_en;
    msi_e nxt_state;
    logic with_data;
  } icr_action_t;
endpackage

// File: rtl/icr_state_array.sv
module icr_state_array
  import icr_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output msi_e              rd_state_o,
  output logic [DATA_W-1:0] rd_d0_o,
  output logic [DATA_W-1:0] rd_d1_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  msi_e              upd_state_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  msi_e              fill_state_i,
  input  logic [DATA_W-1:0] fill_d0_i,
  input  logic [DATA_W-1:0] fill_d1_i
);
  localparam int NLINES = 1 << IDX_W;

  msi_e              st_q [NLINES];
  logic [DATA_W-1:0] d0_q [NLINES];
  logic [DATA_W-1:0] d1_q [NLINES];

  // intervention updates win over refill
  logic fill_eff;
  msi_e fill_st_clean;
  assign fill_eff      = fill_en_i & ~upd_en_i;
  assign fill_st_clean = (fill_state_i == MSI_S || fill_state_i == MSI_M) ? fill_state_i : MSI_I;

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[l] <= MSI_I;
        d0_q[l] <= '0;
        d1_q[l] <= '0;
      end else if (upd_en_i && upd_idx_i == IDX_W'(l)) begin
        st_q[l] <= upd_state_i;
      end else if (fill_eff && fill_idx_i == IDX_W'(l)) begin
        st_q[l] <= fill_st_clean;
        d0_q[l] <= fill_d0_i;
        d1_q[l] <= fill_d1_i;
      end
    end

    AST_DATA_KEPT_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_en_i |=> $stable(d0_q[l]) && $stable(d1_q[l])); // R10
  end

  assign rd_state_o = st_q[rd_idx_i];
  assign rd_d0_o    = d0_q[rd_idx_i];
  assign rd_d1_o    = d1_q[rd_idx_i];
endmodule

// File: rtl/icr_policy.sv
module icr_policy
  import icr_pkg::*;
(
  input  ivcmd_e      cmd_i,
  input  logic        is_sys_i,
  input  logic        id_hit_i,
  input  msi_e        cur_i,
  output icr_action_t act_o
);
  always_comb begin
    act_o.upd_en    = 1'b0;
    act_o.nxt_state = cur_i;
    act_o.with_data = 1'b0;
    if (is_sys_i && id_hit_i) begin
      unique case (cmd_i)
        IV_RDSH: if (cur_i == MSI_M) begin
          act_o.upd_en    = 1'b1;
          act_o.nxt_state = MSI_S;
          act_o.with_data = 1'b1;
        end
        IV_RDOW: if (cur_i != MSI_I) begin
          act_o.upd_en    = 1'b1;
          act_o.nxt_state = MSI_I;
          act_o.with_data = (cur_i == MSI_M);
        end
        IV_UPG: if (cur_i != MSI_I) begin
          act_o.upd_en    = 1'b1;
          act_o.nxt_state = MSI_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/icr_resp_seq.sv
module icr_resp_seq
  import icr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              with_data_i,
  input  msi_e              load_state_i,
  input  logic [DATA_W-1:0] load_d0_i,
  input  logic [DATA_W-1:0] load_d1_i,
  output logic              idle_o,
  output logic              resp_valid_o,
  input  logic              resp_ready_i,
  output rcode_e            resp_code_o,
  output msi_e              resp_state_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_last_o
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_B0, SQ_B1} sq_e;

  sq_e               sq_q, sq_d;
  logic              dat_q;
  msi_e              st_q;
  logic [DATA_W-1:0] w0_q, w1_q;

  always_comb begin
    sq_d = sq_q;
    unique case (sq_q)
      SQ_IDLE: if (load_i) sq_d = SQ_B0;
      SQ_B0:   if (resp_ready_i) sq_d = dat_q ? SQ_B1 : SQ_IDLE;
      SQ_B1:   if (resp_ready_i) sq_d = SQ_IDLE;
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q  <= SQ_IDLE;
      dat_q <= 1'b0;
      st_q  <= MSI_I;
      w0_q  <= '0;
      w1_q  <= '0;
    end else begin
      sq_q <= sq_d;
      if (load_i && sq_q == SQ_IDLE) begin
        dat_q <= with_data_i;
        st_q  <= load_state_i;
        w0_q  <= with_data_i ? load_d0_i : '0;
        w1_q  <= with_data_i ? load_d1_i : '0;
      end
    end
  end

  assign idle_o       = (sq_q == SQ_IDLE);
  assign resp_valid_o = (sq_q != SQ_IDLE);
  assign resp_code_o  = (sq_q == SQ_IDLE) ? RC_NONE : (dat_q ? RC_DATA : RC_ACK);
  assign resp_state_o = st_q;
  assign resp_data_o  = (sq_q == SQ_B1) ? w1_q : ((sq_q == SQ_B0) ? w0_q : '0);
  assign resp_last_o  = (sq_q == SQ_B1) || (sq_q == SQ_B0 && !dat_q);

  AST_RESP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=> resp_valid_o && $stable(resp_data_o) && $stable(resp_code_o) && $stable(resp_last_o)); // R9
  AST_DATA_TWO_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_ready_i && !resp_last_o) |=> resp_valid_o && resp_last_o && resp_code_o == RC_DATA); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RC_ACK) |-> resp_last_o && resp_data_o == '0); // R4
endmodule

// File: rtl/icr_intervention_responder.sv
module icr_intervention_responder
  import icr_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 32,
  parameter int CID_W   = 3,
  parameter int CORE_ID = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_cmd_i,
  input  logic [IDX_W-1:0]  req_addr_i,
  input  logic              req_sys_i,
  input  logic [CID_W-1:0]  req_cid_i,
  output logic              resp_valid_o,
  input  logic              resp_ready_i,
  output logic [1:0]        resp_code_o,
  output logic [1:0]        resp_state_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_last_o,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [1:0]        fill_state_i,
  input  logic [DATA_W-1:0] fill_d0_i,
  input  logic [DATA_W-1:0] fill_d1_i
);
  localparam logic [CID_W-1:0] MY_CID = CID_W'(CORE_ID);

  msi_e              rd_state;
  logic [DATA_W-1:0] rd_d0, rd_d1;
  icr_action_t       act;
  logic              idle, acc, id_hit;
  rcode_e            code_e;
  msi_e              rstate_e;

  assign id_hit = (req_cid_i == MY_CID);
  assign acc    = req_valid_i & idle;

  icr_state_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (req_addr_i),
    .rd_state_o   (rd_state),
    .rd_d0_o      (rd_d0),
    .rd_d1_o      (rd_d1),
    .upd_en_i     (acc & act.upd_en),
    .upd_idx_i    (req_addr_i),
    .upd_state_i  (act.nxt_state),
    .fill_en_i    (fill_valid_i & ~acc),
    .fill_idx_i   (fill_idx_i),
    .fill_state_i (msi_e'(fill_state_i)),
    .fill_d0_i    (fill_d0_i),
    .fill_d1_i    (fill_d1_i)
  );

  icr_policy u_policy (
    .cmd_i    (ivcmd_e'(req_cmd_i)),
    .is_sys_i (req_sys_i),
    .id_hit_i (id_hit),
    .cur_i    (rd_state),
    .act_o    (act)
  );

  icr_resp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (acc),
    .with_data_i  (act.with_data),
    .load_state_i (rd_state),
    .load_d0_i    (rd_d0),
    .load_d1_i    (rd_d1),
    .idle_o       (idle),
    .resp_valid_o (resp_valid_o),
    .resp_ready_i (resp_ready_i),
    .resp_code_o  (code_e),
    .resp_state_o (rstate_e),
    .resp_data_o  (resp_data_o),
    .resp_last_o  (resp_last_o)
  );

  assign req_ready_o  = idle;
  assign resp_code_o  = code_e;
  assign resp_state_o = rstate_e;

  AST_RESP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o); // R9
  AST_SELF_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_sys_i) |=> resp_code_o == RC_ACK && resp_state_o == $past(rd_state)); // R6
  AST_RDSH_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_sys_i && id_hit && req_cmd_i == IV_RDSH && rd_state == MSI_M) |=> resp_code_o == RC_DATA); // R2
  AST_INVALID_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_state == MSI_I) |=> resp_code_o == RC_ACK && resp_state_o == MSI_I); // R7
  AST_FOREIGN_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_sys_i && !id_hit) |=> resp_code_o == RC_ACK); // R8
endmodule

// File: tb/icr_intervention_responder_tb_top.sv
module icr_intervention_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3;
  localparam int DATA_W = 32;
  localparam int CID_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              req_valid = 1'b0, req_sys = 1'b0, resp_ready = 1'b0, fill_valid = 1'b0;
  logic [1:0]        req_cmd = '0, fill_state = '0;
  logic [IDX_W-1:0]  req_addr = '0, fill_idx = '0;
  logic [CID_W-1:0]  req_cid = '0;
  logic [DATA_W-1:0] fill_d0 = '0, fill_d1 = '0;
  logic              req_ready, resp_valid, resp_last;
  logic [1:0]        resp_code, resp_state;
  logic [DATA_W-1:0] resp_data;

  icr_intervention_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_sys_i(req_sys), .req_cid_i(req_cid),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready), .resp_code_o(resp_code),
    .resp_state_o(resp_state), .resp_data_o(resp_data), .resp_last_o(resp_last),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_state_i(fill_state),
    .fill_d0_i(fill_d0), .fill_d1_i(fill_d1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] w0(input int idx); return 32'hA000_0000 + idx; endfunction
  function automatic logic [DATA_W-1:0] w1(input int idx); return 32'hB000_0000 + idx; endfunction

  task automatic fill(input int idx, input logic [1:0] st);
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = IDX_W'(idx); fill_state = st;
    fill_d0 = w0(idx); fill_d1 = w1(idx);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // exp_code 1 = ack, 2 = data
  task automatic intv(input string tag, input logic [1:0] cmd, input int idx, input logic sys,
                      input logic [CID_W-1:0] cid, input logic [1:0] exp_code, input logic [1:0] exp_st);
    @(negedge clk);
    chk({tag, " ready idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_cmd = cmd; req_addr = IDX_W'(idx); req_sys = sys; req_cid = cid;
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(resp_valid), 64'd1);
    chk({tag, " code"}, 64'(resp_code), 64'(exp_code));
    chk({tag, " state"}, 64'(resp_state), 64'(exp_st));
    chk({tag, " data0"}, 64'(resp_data), (exp_code == 2'd2) ? 64'(w0(idx)) : 64'd0);
    chk({tag, " last0"}, 64'(resp_last), (exp_code == 2'd2) ? 64'd0 : 64'd1);
    if (exp_code == 2'd2) begin
      @(negedge clk);
      chk({tag, " data1"}, 64'(resp_data), 64'(w1(idx)));
      chk({tag, " last1"}, 64'(resp_last), 64'd1);
    end
    @(negedge clk);
    chk({tag, " drained"}, 64'(resp_valid), 64'd0);
    resp_ready = 1'b0;
  endtask

  // {cmd[2], idx[3], sys, cid[3], exp_code[2], exp_state[2]}
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 3'd2, 2'd1, 2'd2},  // R6 self on M
    {2'd0, 3'd0, 1'b1, 3'd2, 2'd2, 2'd2},  // R2 rdsh on M -> S
    {2'd0, 3'd0, 1'b1, 3'd2, 2'd1, 2'd1},  // R5 rdsh on S stays S, confirms R2
    {2'd1, 3'd1, 1'b1, 3'd2, 2'd2, 2'd2},  // R3 rdow on M -> I
    {2'd1, 3'd1, 1'b0, 3'd2, 2'd1, 2'd0},  // R7 confirms R3
    {2'd2, 3'd2, 1'b1, 3'd2, 2'd1, 2'd1},  // R4 upg on S
    {2'd2, 3'd2, 1'b1, 3'd2, 2'd1, 2'd0},  // R7 upg on I
    {2'd1, 3'd3, 1'b1, 3'd2, 2'd1, 2'd1},  // R5 rdow on S -> I
    {2'd0, 3'd3, 1'b0, 3'd2, 2'd1, 2'd0},  // R5 confirm invalid
    {2'd1, 3'd5, 1'b1, 3'd5, 2'd1, 2'd2},  // R8 foreign id on M
    {2'd1, 3'd5, 1'b1, 3'd2, 2'd2, 2'd2},  // R8 line still M
    {2'd2, 3'd7, 1'b1, 3'd2, 2'd1, 2'd2},  // R4 upg on M, no data
    {2'd0, 3'd7, 1'b0, 3'd2, 2'd1, 2'd0},  // R4 confirm invalid
    {2'd3, 3'd6, 1'b1, 3'd2, 2'd1, 2'd1},  // R11 reserved cmd
    {2'd0, 3'd6, 1'b0, 3'd2, 2'd1, 2'd1}   // R11 line still S
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset valid", 64'(resp_valid), 64'd0);
    rst_n = 1'b1;
    chk("R1 post-reset ready", 64'(req_ready), 64'd1);
    intv("R1 line0 invalid", 2'd0, 0, 1'b0, 3'd2, 2'd1, 2'd0);
    intv("R7 system on invalid", 2'd0, 6, 1'b1, 3'd2, 2'd1, 2'd0);

    fill(0, 2'd2); fill(1, 2'd2); fill(2, 2'd1); fill(3, 2'd1);
    fill(5, 2'd2); fill(6, 2'd1); fill(7, 2'd2);
    fill(4, 2'd3);
    intv("R10 fill code3 gives I", 2'd0, 4, 1'b0, 3'd2, 2'd1, 2'd0);

    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("table vec %0d", v);
      intv(t, VEC[v][12:11], int'(VEC[v][10:8]), VEC[v][7], VEC[v][6:4], VEC[v][3:2], VEC[v][1:0]);
    end

    // R10: fill in the accept cycle is dropped
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd0; req_addr = 3'd2; req_sys = 1'b0; req_cid = 3'd2;
    fill_valid = 1'b1; fill_idx = 3'd4; fill_state = 2'd2; fill_d0 = w0(4); fill_d1 = w1(4);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    @(negedge clk);
    resp_ready = 1'b0;
    intv("R10 collided fill ignored", 2'd0, 4, 1'b0, 3'd2, 2'd1, 2'd0);

    // R9: backpressure on a data response
    fill(0, 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd0; req_addr = 3'd0; req_sys = 1'b1; req_cid = 3'd2;
    resp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 hold valid", 64'(resp_valid), 64'd1);
      chk("R9 hold data", 64'(resp_data), 64'(w0(0)));
      chk("R9 hold last", 64'(resp_last), 64'd0);
      chk("R9 ready low", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R9 beat1 data", 64'(resp_data), 64'(w1(0)));
    chk("R9 ready low at last", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R9 ready back", 64'(req_ready), 64'd1);
    resp_ready = 1'b0;
    intv("R2 state S after backpressure", 2'd0, 0, 1'b0, 3'd2, 2'd1, 2'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule